// File: doc/BRIEF.md
# Command Ring Buffer Pointer Controller

This block keeps the bookkeeping for a circular command buffer held in memory. A CPU-side write gatherer deposits commands in 32-byte lines and signals each line with a one-cycle strobe. A graphics-side reader drains the buffer and signals each line it has consumed with another one-cycle strobe. The block does not move any data. It tracks the ring's start and end addresses, the write and read positions, a pending-byte count, two watermark thresholds and a breakpoint address.

From that state it derives the overflow, underflow and breakpoint flags, a status word, and a level-sensitive interrupt. Every address-like value is 32 bits wide. Software reaches each one as a pair of 16-bit halves over a plain single-cycle register bus: writes are strobed and reads are combinational. A control word gates the gatherer link, the reader, the breakpoint compare and the three interrupt sources.

Register map by `reg_addr`. For word index k, address 2k is bits 15:0 and address 2k+1 is bits 31:16. The word indices are: 0 ring start, 1 ring end, 2 high threshold, 3 low threshold, 4 write position, 5 read position, 6 pending count, 7 breakpoint address. Address 16 is the control word and address 17 is the status word. Any other address reads 0.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: A write strobe accepted while link enable (control bit 4) is set moves the write position to the ring start when it equals the ring end, and otherwise adds 32 to it.
- R2: Each accepted write strobe adds 32 to the pending count. With link enable clear, a write strobe changes neither the write position nor the pending count.
- R3: A consume strobe moves the read position to the ring start when it equals the ring end, otherwise adds 32 to it, and subtracts 32 from the pending count. An accepted write strobe and a consume strobe in the same cycle leave the pending count unchanged.
- R4: Status bit 0 (over) is set exactly when the pending count is strictly greater than the high threshold. Status bit 1 (under) is set exactly when the pending count is strictly less than the low threshold.
- R5: Status bit 4 (breakpoint hit) is set exactly when breakpoint enable (control bit 1) is set and the breakpoint address equals the read position. Clearing the enable clears the bit.
- R6: `irq` is high exactly when reader enable (control bit 0) is set and at least one of these holds: hit with control bit 5, over with control bit 2, or under with control bit 3.
- R7: Status bit 2 (reader idle) is set when the pending count is zero or the read position equals the write position. Status bit 3 (command idle) is set when the pending count is zero, the hit bit is set, or reader enable is clear.
- R8: A write to a low half stores the data ANDed with 0xFFE0. A write to a high half stores the data ANDed with 0x03FF, or with 0x1FFF when `WIDE_ADDR` is 1.
- R9: Reading the pending-count word returns write minus read when the write position is at or above the read position. Otherwise it returns end minus read, plus write minus start, plus 32.
- R10: After reset, status reads 0x000C and every stored word and the control word read 0.
- R11: A write to one half of a word replaces only that half and keeps the stored other half. A register write takes priority over a strobe update of the same word in that cycle.
- R12: Writing the status address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| line_wr | input | 1 | One-cycle strobe: gatherer deposited one 32-byte line |
| line_done | input | 1 | One-cycle strobe: reader consumed one 32-byte line |
| irq | output | 1 | Level interrupt |

## Verification
The strobe properties condition on cycles without a register write, because a write takes priority over strobe updates of the same word. The alignment property assumes the ring start and ring end are only loaded through the masked halves, so every position stays a multiple of 32. The stimulus programs a ring whose end is a whole number of lines above its start. It issues strobes only after that setup, and it keeps the write and read strobes within the ring so the pending count never goes negative. It also drives a same-cycle write and consume, a wrap of both positions, and threshold equality cases.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam int LINE_BYTES = 32;
  localparam int NUM_WORDS  = 8;
  localparam int REG_AW     = 5;
  localparam int CTRL_W     = 6;
  localparam int STAT_W     = 5;

  localparam int IDX_START = 0;
  localparam int IDX_END   = 1;
  localparam int IDX_HITH  = 2;
  localparam int IDX_LOTH  = 3;
  localparam int IDX_WPOS  = 4;
  localparam int IDX_RPOS  = 5;
  localparam int IDX_PEND  = 6;
  localparam int IDX_BKPT  = 7;

  localparam logic [REG_AW-1:0] ADDR_CTRL = REG_AW'(2 * NUM_WORDS);
  localparam logic [REG_AW-1:0] ADDR_STAT = REG_AW'(2 * NUM_WORDS + 1);

  // control word, bit 0 first from the right
  typedef struct packed {
    logic hit_ie;   // 5
    logic link_en;  // 4
    logic under_ie; // 3
    logic over_ie;  // 2
    logic bp_en;    // 1
    logic rd_en;    // 0
  } ctrl_t;

  typedef struct packed {
    logic hit;      // 4
    logic cmd_idle; // 3
    logic rd_idle;  // 2
    logic under;    // 1
    logic over;     // 0
  } stat_t;
endpackage

// File: rtl/cmd_ring_step.sv
module cmd_ring_step #(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ring_lo,
  input  logic [AW-1:0] ring_hi,
  output logic [AW-1:0] nxt
);
  // advance one line, folding back to the ring start at the end address
  assign nxt = (cur == ring_hi) ? ring_lo : cur + AW'(STEP);
endmodule

// File: rtl/cmd_ring_view.sv
module cmd_ring_view #(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic [AW-1:0] wpos,
  input  logic [AW-1:0] rpos,
  input  logic [AW-1:0] ring_lo,
  input  logic [AW-1:0] ring_hi,
  output logic [AW-1:0] span
);
  logic [AW-1:0] direct_span;
  logic [AW-1:0] folded_span;

  assign direct_span = wpos - rpos;
  assign folded_span = (ring_hi - rpos) + (wpos - ring_lo) + AW'(STEP);
  assign span        = (wpos >= rpos) ? direct_span : folded_span;
endmodule

// File: rtl/cmd_ring_flags.sv
module cmd_ring_flags
  import cmd_ring_pkg::*;
#(
  parameter int AW = 32
) (
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] pend,
  input  logic [AW-1:0] hi_th,
  input  logic [AW-1:0] lo_th,
  input  logic [AW-1:0] bkpt,
  input  logic [AW-1:0] rpos,
  input  logic [AW-1:0] wpos,
  output stat_t         stat,
  output logic          irq
);
  logic empty;

  assign empty         = (pend == '0);
  assign stat.over     = pend > hi_th;
  assign stat.under    = pend < lo_th;
  assign stat.hit      = ctrl.bp_en && (bkpt == rpos);
  assign stat.rd_idle  = empty || (rpos == wpos);
  assign stat.cmd_idle = empty || stat.hit || !ctrl.rd_en;

  assign irq = ctrl.rd_en && ((stat.hit   && ctrl.hit_ie)  ||
                              (stat.over  && ctrl.over_ie) ||
                              (stat.under && ctrl.under_ie));
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit WIDE_ADDR = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [cmd_ring_pkg::REG_AW-1:0] reg_addr,
  input  logic [ADDR_W/2-1:0]          reg_wdata,
  output logic [ADDR_W/2-1:0]          reg_rdata,
  input  logic                         line_wr,
  input  logic                         line_done,
  output logic                         irq
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int IDX_W  = $clog2(NUM_WORDS);
  localparam logic [HALF_W-1:0] LO_MASK = HALF_W'(~(LINE_BYTES - 1));
  localparam logic [HALF_W-1:0] HI_MASK = WIDE_ADDR ? HALF_W'(16'h1FFF) : HALF_W'(16'h03FF);

  logic [ADDR_W-1:0]    word_q   [NUM_WORDS];
  logic [ADDR_W-1:0]    word_nxt [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_upd;
  ctrl_t                ctrl_q;
  stat_t                stat;

  logic [ADDR_W-1:0] start_q, end_q, wpos_q, rpos_q, pend_q;
  logic [ADDR_W-1:0] wpos_adv, rpos_adv, pend_view;
  logic              accept;

  assign start_q = word_q[IDX_START];
  assign end_q   = word_q[IDX_END];
  assign wpos_q  = word_q[IDX_WPOS];
  assign rpos_q  = word_q[IDX_RPOS];
  assign pend_q  = word_q[IDX_PEND];
  assign accept  = line_wr && ctrl_q.link_en;

  cmd_ring_step #(.AW(ADDR_W), .STEP(LINE_BYTES)) u_wstep (
    .cur(wpos_q), .ring_lo(start_q), .ring_hi(end_q), .nxt(wpos_adv));

  cmd_ring_step #(.AW(ADDR_W), .STEP(LINE_BYTES)) u_rstep (
    .cur(rpos_q), .ring_lo(start_q), .ring_hi(end_q), .nxt(rpos_adv));

  cmd_ring_view #(.AW(ADDR_W), .STEP(LINE_BYTES)) u_view (
    .wpos(wpos_q), .rpos(rpos_q), .ring_lo(start_q), .ring_hi(end_q), .span(pend_view));

  cmd_ring_flags #(.AW(ADDR_W)) u_flags (
    .ctrl(ctrl_q), .pend(pend_q), .hi_th(word_q[IDX_HITH]), .lo_th(word_q[IDX_LOTH]),
    .bkpt(word_q[IDX_BKPT]), .rpos(rpos_q), .wpos(wpos_q), .stat(stat), .irq(irq));

  // strobe-driven updates
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) word_nxt[i] = word_q[i];
    word_upd = '0;
    word_nxt[IDX_WPOS] = wpos_adv;
    word_upd[IDX_WPOS] = accept;
    word_nxt[IDX_RPOS] = rpos_adv;
    word_upd[IDX_RPOS] = line_done;
    word_nxt[IDX_PEND] = accept ? pend_q + ADDR_W'(LINE_BYTES) : pend_q - ADDR_W'(LINE_BYTES);
    word_upd[IDX_PEND] = accept ^ line_done;
  end

  // register writes win over strobe updates of the same word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
      ctrl_q <= '0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (reg_we && reg_addr == REG_AW'(2 * i))
          word_q[i][HALF_W-1:0] <= reg_wdata & LO_MASK;
        else if (reg_we && reg_addr == REG_AW'(2 * i + 1))
          word_q[i][ADDR_W-1:HALF_W] <= reg_wdata & HI_MASK;
        else if (word_upd[i])
          word_q[i] <= word_nxt[i];
      end
      if (reg_we && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  // read mux
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_word;

  assign rd_idx  = reg_addr[IDX_W:1];
  assign rd_word = (int'(rd_idx) == IDX_PEND) ? pend_view : word_q[rd_idx];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_CTRL)
      reg_rdata = reg_addr[0] ? rd_word[ADDR_W-1:HALF_W] : rd_word[HALF_W-1:0];
    else if (reg_addr == ADDR_CTRL)
      reg_rdata = HALF_W'(ctrl_q);
    else if (reg_addr == ADDR_STAT)
      reg_rdata = HALF_W'(stat);
  end
endmodule

// File: rtl/cmd_ring_ctrl_chk.sv
module cmd_ring_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          line_wr,
  input logic          line_done,
  input logic [5:0]    ctrl,
  input logic [AW-1:0] start_a,
  input logic [AW-1:0] end_a,
  input logic [AW-1:0] wpos,
  input logic [AW-1:0] rpos,
  input logic [AW-1:0] pend,
  input logic [4:0]    stat,
  input logic          irq
);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wr && ctrl[4] && !reg_we && wpos == end_a) |=> (wpos == $past(start_a)));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wr && ctrl[4] && !reg_we && wpos != end_a) |=> (wpos == $past(wpos) + AW'(32)));

  a_r2_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wr && !ctrl[4] && !line_done && !reg_we) |=> ($stable(wpos) && $stable(pend)));

  a_r3_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wr && ctrl[4] && line_done && !reg_we) |=> $stable(pend));

  a_r5_hit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |-> !stat[4]);

  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !irq);

  a_r7_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> stat[3]);

  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (wpos[4:0] == 5'd0) && (rpos[4:0] == 5'd0));
endmodule

bind cmd_ring_ctrl cmd_ring_ctrl_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .line_wr(line_wr), .line_done(line_done),
  .ctrl(ctrl_q), .start_a(start_q), .end_a(end_q), .wpos(wpos_q), .rpos(rpos_q),
  .pend(pend_q), .stat(stat), .irq(irq));

// File: tb/cmd_ring_ctrl_test.sv
`timescale 1ns/1ps
module cmd_ring_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        line_wr = 1'b0;
  logic        line_done = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cmd_ring_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_wr(line_wr),
    .line_done(line_done), .irq(irq));

  // behavioural reference model
  logic [31:0] m_w [8];
  logic [5:0]  m_ctrl;

  function automatic logic [4:0] m_stat();
    logic hit, over, under, ri, ci;
    hit   = m_ctrl[1] && (m_w[7] == m_w[5]);
    over  = m_w[6] > m_w[2];
    under = m_w[6] < m_w[3];
    ri    = (m_w[6] == 0) || (m_w[5] == m_w[4]);
    ci    = (m_w[6] == 0) || hit || !m_ctrl[0];
    return {hit, ci, ri, under, over};
  endfunction

  function automatic logic m_irq();
    logic [4:0] s;
    s = m_stat();
    return m_ctrl[0] && ((s[4] && m_ctrl[5]) || (s[0] && m_ctrl[2]) || (s[1] && m_ctrl[3]));
  endfunction

  function automatic logic [15:0] m_read(input logic [4:0] a);
    logic [31:0] v;
    if (a < 16) begin
      if (a[4:1] == 6)
        v = (m_w[4] >= m_w[5]) ? m_w[4] - m_w[5] : m_w[1] - m_w[5] + m_w[4] - m_w[0] + 32;
      else
        v = m_w[a[3:1]];
      return a[0] ? v[31:16] : v[15:0];
    end
    if (a == 16) return {10'd0, m_ctrl};
    if (a == 17) return {11'd0, m_stat()};
    return 16'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_w[i] <= 32'd0;
      m_ctrl <= 6'd0;
    end else begin
      logic [31:0] nw [8];
      for (int i = 0; i < 8; i++) nw[i] = m_w[i];
      if (line_wr && m_ctrl[4]) begin
        nw[4] = (m_w[4] == m_w[1]) ? m_w[0] : m_w[4] + 32;
        nw[6] = nw[6] + 32;
      end
      if (line_done) begin
        nw[5] = (m_w[5] == m_w[1]) ? m_w[0] : m_w[5] + 32;
        nw[6] = nw[6] - 32;
      end
      if (reg_we && reg_addr < 16) begin
        if (reg_addr[0]) nw[reg_addr[3:1]] = {reg_wdata & 16'h03FF, m_w[reg_addr[3:1]][15:0]};
        else             nw[reg_addr[3:1]] = {m_w[reg_addr[3:1]][31:16], reg_wdata & 16'hFFE0};
      end
      if (reg_we && reg_addr == 16) m_ctrl <= reg_wdata[5:0];
      for (int i = 0; i < 8; i++) m_w[i] <= nw[i];
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      checks++;
      if (irq !== m_irq()) begin
        fails++;
        $display("FAIL R6 model irq: actual %0b expected %0b", irq, m_irq());
      end
      checks++;
      if (reg_rdata !== m_read(reg_addr)) begin
        fails++;
        $display("FAIL %s model read addr %0d: actual %h expected %h",
                 (reg_addr == 17) ? "R7" : (reg_addr[4:1] == 6) ? "R9" : "R8",
                 reg_addr, reg_rdata, m_read(reg_addr));
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse(input logic w, input logic c);
    @(negedge clk); line_wr = w; line_done = c;
    @(negedge clk); line_wr = 1'b0; line_done = 1'b0;
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); reg_we = 1'b0; reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    expect_rd(17, 16'h000C, "R10");
    expect_rd(16, 16'h0000, "R10");
    expect_rd(8,  16'h0000, "R10");
    expect_irq(1'b0, "R10");
    // ring setup: start 0x0010_0000, end 0x0010_0080
    wr(1, 16'h0010); wr(2, 16'h0080); wr(3, 16'h0010);
    wr(9, 16'h0010); wr(11, 16'h0010);
    wr(4, 16'h0060); wr(6, 16'h0040);
    // R8 masking, R11 half preservation
    wr(8, 16'hFFFF); expect_rd(8, 16'hFFE0, "R8");
    wr(9, 16'hFFFF); expect_rd(9, 16'h03FF, "R8");
    expect_rd(8, 16'hFFE0, "R11");
    wr(8, 16'h0000); wr(9, 16'h0010);
    // R2 link off: strobe ignored
    pulse(1'b1, 1'b0);
    expect_rd(8, 16'h0000, "R2");
    expect_irq(1'b0, "R6");
    // enable reader, link, over/under interrupts
    wr(16, 16'h001D);
    expect_irq(1'b1, "R6");
    expect_rd(17, 16'h000E, "R4");
    repeat (4) pulse(1'b1, 1'b0);
    expect_rd(8,  16'h0080, "R1");
    expect_rd(12, 16'h0080, "R9");
    expect_rd(17, 16'h0001, "R4");
    pulse(1'b0, 1'b1);
    expect_rd(10, 16'h0020, "R3");
    expect_rd(17, 16'h0000, "R4");
    expect_irq(1'b0, "R6");
    pulse(1'b1, 1'b0);
    expect_rd(8,  16'h0000, "R1");
    expect_rd(9,  16'h0010, "R1");
    expect_rd(12, 16'h0080, "R9");
    pulse(1'b1, 1'b1);
    expect_rd(12, 16'h0080, "R3");
    expect_rd(17, 16'h0001, "R4");
    // breakpoint
    wr(14, 16'h0040); wr(15, 16'h0010);
    wr(16, 16'h001F);
    expect_rd(17, 16'h0019, "R5");
    pulse(1'b0, 1'b1);
    expect_rd(17, 16'h0000, "R5");
    wr(14, 16'h0060);
    wr(16, 16'h0033);
    expect_irq(1'b1, "R6");
    wr(16, 16'h0031);
    expect_rd(17, 16'h0000, "R5");
    expect_irq(1'b0, "R6");
    // reader off, underflow, read wrap
    wr(16, 16'h0018);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    expect_rd(10, 16'h0000, "R3");
    expect_irq(1'b0, "R6");
    expect_rd(17, 16'h000A, "R7");
    // R12 status write has no effect
    wr(17, 16'hFFFF);
    expect_rd(17, 16'h000A, "R12");
    // R11 high half of pending count keeps low half
    wr(13, 16'h0001);
    expect_rd(17, 16'h0009, "R11");
    wr(13, 16'h0000);
    expect_rd(17, 16'h000A, "R11");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule